// File: doc/BRIEF.md
# Double-Buffered Serial Grayscale Latch

This block takes per-channel brightness words for a sixteen-channel, sixteen-bit PWM LED driver over a serial clock/data link. Bits enter a 257-stage shift chain whose far end leaves the block for daisy-chaining. The top stage of the chain decides what a latch pulse does. When it is clear, the lower 256 bits become the pending frame. When it is set, a strobe goes to a separate control-data path.

The pending frame reaches the active stage, which feeds the PWM timing logic, only on one of three events. The first is the end of a full grayscale-clock period when repeat mode is on. The second is the latch pulse itself when timing-reset mode is on. The third is any cycle in which the blanking bit is high. The serial clock, latch and grayscale clock are sampled in one system clock domain, and only their rising edges act.

Top module: `gsl_top`

## Requirements
- R1: `serOut` always shows stage 256 of the chain; a bit shifted in appears on `serOut` after 257 further rising `serClk` edges counting its own.
- R2: Each rising `serClk` edge shifts the chain by exactly one place, with `serIn` entering stage 0; holding `serClk` high for many cycles shifts only once.
- R3: A rising `latchIn` edge while stage 256 is 0 copies stages 255:0 into the pending frame; channel n occupies bits 16n+15 down to 16n.
- R4: A rising `latchIn` edge while stage 256 is 1 raises `ctlStrobe` for one cycle with `ctlData` equal to stages 255:0, and leaves the pending frame unchanged.
- R5: With `timingReset` high, a grayscale write copies stages 255:0 straight to `gsActive` in the same cycle it loads the pending frame, and it clears the grayscale-clock counter.
- R6: With `autoRepeat` high, the 2^CNT_W-th rising `gsClk` edge (65,536 by default) copies the pending frame to `gsActive`; with it low, that edge leaves `gsActive` unchanged.
- R7: While `blank` is high, `gsActive` takes the pending frame on every cycle.
- R8: With no transfer event, `gsActive` holds its value across new grayscale writes.
- R9: When `latchIn` and `serClk` rise in the same cycle, the latch uses the chain contents from before that shift.
- R10: The grayscale-clock counter starts at 0 after reset and after every R5 clear, so the next R6 transfer needs a full 2^CNT_W edges from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low async reset of edge detectors and counter |
| serClk | input | 1 | Serial shift clock, sampled |
| serIn | input | 1 | Serial data into stage 0 |
| latchIn | input | 1 | Latch request, sampled |
| gsClk | input | 1 | Grayscale counting clock, sampled |
| autoRepeat | input | 1 | Transfer at end of each grayscale period |
| timingReset | input | 1 | Transfer on each grayscale write |
| blank | input | 1 | Continuous transfer while high |
| serOut | output | 1 | Chain stage 256 |
| gsActive | output | 256 | Active grayscale frame |
| ctlStrobe | output | 1 | One-cycle control-load pulse |
| ctlData | output | 256 | Chain stages 255:0 for the control path |

## Verification
The bench targets the routing decision made by the top chain stage. A design that tested the wrong stage, or tested it after the shift, would load a control word as grayscale, or miss the pending frame, whenever a latch and a shift coincide. It counts grayscale-clock edges across a counter clear and checks both sides of the wrap. An off-by-one counter or an uncleared counter moves the repeat transfer by one edge. It also checks that the active frame holds while new frames are written. A design that leaked the pending frame through would show the new data early.

// File: rtl/gsl_pkg.sv
package gsl_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftEn;  // advance the chain
    logic gsLoad;   // chain -> pending frame
    logic xferSr;   // chain -> active frame (timing-reset write)
    logic xferL1;   // pending -> active frame
  } gsStrobe_t;
endpackage

// File: rtl/gsl_ctrl.sv
module gsl_ctrl
  import gsl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      serClk,
  input  logic      latchIn,
  input  logic      gsClk,
  input  logic      autoRepeat,
  input  logic      timingReset,
  input  logic      blank,
  input  logic      srMsb,
  output gsStrobe_t strb,
  output logic      ctlStrobe
);
  logic serClkQ, latchQ, gsClkQ;
  logic serRise, latRise, gsRise;
  logic gsWrite, clearCnt, wrapHit;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ <= 1'b0;
      latchQ  <= 1'b0;
      gsClkQ  <= 1'b0;
    end else begin
      serClkQ <= serClk;
      latchQ  <= latchIn;
      gsClkQ  <= gsClk;
    end
  end

  assign serRise = serClk & ~serClkQ;
  assign latRise = latchIn & ~latchQ;
  assign gsRise  = gsClk & ~gsClkQ;

  // srMsb is the pre-shift value, so a coincident shift cannot steer routing
  assign gsWrite   = latRise & ~srMsb;
  assign ctlStrobe = latRise & srMsb;
  assign clearCnt  = gsWrite & timingReset;
  assign wrapHit   = gsRise & (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (clearCnt) cnt <= '0;
    else if (gsRise)   cnt <= cnt + 1'b1;
  end

  always_comb begin
    strb.shiftEn = serRise;
    strb.gsLoad  = gsWrite;
    strb.xferSr  = clearCnt;
    strb.xferL1  = blank | (autoRepeat & wrapHit);
  end

  a_r4_route_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.gsLoad && ctlStrobe));
  a_r5_counter_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferSr |=> cnt == '0);
  a_r10_counter_step: assert property (@(posedge clk) disable iff (!rstN)
    (gsRise && !strb.xferSr) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  a_r10_counter_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!gsRise && !strb.xferSr) |=> $stable(cnt));
endmodule

// File: rtl/gsl_datapath.sv
module gsl_datapath
  import gsl_pkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int GS_BITS  = 16,
  localparam int FRAME_W = CHANNELS * GS_BITS,
  localparam int SR_W    = FRAME_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serIn,
  input  gsStrobe_t          strb,
  output logic               srMsb,
  output logic [FRAME_W-1:0] srLow,
  output logic [FRAME_W-1:0] gsActive
);
  logic [SR_W-1:0]    chain;
  logic [FRAME_W-1:0] pendFlat;

  // no reset: contents are undefined after power-up
  always_ff @(posedge clk) begin
    if (strb.shiftEn) chain <= {chain[SR_W-2:0], serIn};
  end

  assign srMsb = chain[SR_W-1];
  assign srLow = chain[FRAME_W-1:0];

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [GS_BITS-1:0] pend, act;
    always_ff @(posedge clk) begin
      if (strb.gsLoad) pend <= chain[ch*GS_BITS +: GS_BITS];
      if (strb.xferSr)      act <= chain[ch*GS_BITS +: GS_BITS];
      else if (strb.xferL1) act <= pend;
    end
    assign pendFlat[ch*GS_BITS +: GS_BITS] = pend;
    assign gsActive[ch*GS_BITS +: GS_BITS] = act;
  end

  a_r2_shift_entry: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> chain[0] == $past(serIn));
  a_r3_pending_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.gsLoad |=> pendFlat == $past(chain[FRAME_W-1:0]));
  a_r7_copy_pending: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xferL1 && !strb.xferSr) |=> gsActive == $past(pendFlat));
  a_r8_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.xferL1 && !strb.xferSr) |=> $stable(gsActive));
endmodule

// File: rtl/gsl_top.sv
module gsl_top
  import gsl_pkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int GS_BITS  = 16,
  parameter int CNT_W    = GS_BITS,
  localparam int FRAME_W = CHANNELS * GS_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serIn,
  input  logic               latchIn,
  input  logic               gsClk,
  input  logic               autoRepeat,
  input  logic               timingReset,
  input  logic               blank,
  output logic               serOut,
  output logic [FRAME_W-1:0] gsActive,
  output logic               ctlStrobe,
  output logic [FRAME_W-1:0] ctlData
);
  gsStrobe_t strb;
  logic      srMsb;

  gsl_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .latchIn(latchIn), .gsClk(gsClk),
    .autoRepeat(autoRepeat), .timingReset(timingReset), .blank(blank),
    .srMsb(srMsb), .strb(strb), .ctlStrobe(ctlStrobe)
  );

  gsl_datapath #(.CHANNELS(CHANNELS), .GS_BITS(GS_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .strb(strb),
    .srMsb(srMsb), .srLow(ctlData), .gsActive(gsActive)
  );

  assign serOut = srMsb;
endmodule

// File: tb/gsl_top_test.sv
module gsl_top_test;
  localparam int CNT_W = 4;
  localparam int FW = 256;

  logic clk = 0, rstN = 0;
  logic serClk = 0, serIn = 0, latchIn = 0, gsClk = 0;
  logic autoRepeat = 0, timingReset = 0, blank = 0;
  logic serOut, ctlStrobe;
  logic [FW-1:0] gsActive, ctlData;

  always #2.5 clk = ~clk;

  gsl_top #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serIn(serIn), .latchIn(latchIn),
    .gsClk(gsClk), .autoRepeat(autoRepeat), .timingReset(timingReset), .blank(blank),
    .serOut(serOut), .gsActive(gsActive), .ctlStrobe(ctlStrobe), .ctlData(ctlData)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [FW:0]   mSr;
  logic [FW-1:0] mL1, mL2;
  int unsigned   mCnt = 0;

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] rndWord();
    logic [FW-1:0] w;
    for (int i = 0; i < 8; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  task automatic shiftBit(input logic b);
    @(negedge clk); serIn = b; serClk = 1; mSr = {mSr[FW-1:0], b};
    @(negedge clk); serClk = 0;
  endtask

  task automatic loadWord(input logic msb, input logic [FW-1:0] d);
    shiftBit(msb);
    for (int i = FW - 1; i >= 0; i--) shiftBit(d[i]);
  endtask

  // latch pulse; optionally with a coincident shift of bit b
  task automatic latPulse(input bit withShift, input logic b);
    @(negedge clk);
    latchIn = 1;
    if (withShift) begin serIn = b; serClk = 1; end
    #1;
    chk(ctlStrobe == mSr[FW], "R4 strobe", {255'b0, ctlStrobe}, {255'b0, mSr[FW]});
    if (mSr[FW]) chk(ctlData == mSr[FW-1:0], "R4 ctlData", ctlData, mSr[FW-1:0]);
    if (!mSr[FW]) begin
      mL1 = mSr[FW-1:0];
      if (timingReset) begin mL2 = mSr[FW-1:0]; mCnt = 0; end
    end
    if (withShift) mSr = {mSr[FW-1:0], b};
    @(negedge clk);
    latchIn = 0; serClk = 0;
    chk(ctlStrobe == 1'b0, "R4 one-cycle strobe", {255'b0, ctlStrobe}, '0);
  endtask

  task automatic blankPulse();
    @(negedge clk); blank = 1;
    @(negedge clk);
    @(negedge clk); blank = 0;
    mL2 = mL1;
  endtask

  task automatic gsPulse();
    @(negedge clk); gsClk = 1;
    if (mCnt == (1 << CNT_W) - 1) begin
      if (autoRepeat) mL2 = mL1;
      mCnt = 0;
    end else mCnt++;
    @(negedge clk); gsClk = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] d, dOld;
    void'($urandom(32'd20240611));
    mSr = '0; mL1 = '0; mL2 = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(ctlStrobe == 1'b0, "R4 reset strobe low", {255'b0, ctlStrobe}, '0);

    // R1 / R2: chain order and edge-only shifting
    d = rndWord();
    loadWord(1'b0, d);
    chk(serOut == 1'b0, "R1 msb on serOut", {255'b0, serOut}, '0);
    shiftBit(1'b1);
    chk(serOut == d[FW-1], "R1 next bit out", {255'b0, serOut}, {255'b0, d[FW-1]});
    @(negedge clk); serIn = 1'b0; serClk = 1; mSr = {mSr[FW-1:0], 1'b0};
    repeat (4) @(negedge clk);
    serClk = 0;
    chk(serOut == mSr[FW], "R2 held clock shifts once", {255'b0, serOut}, {255'b0, mSr[FW]});

    // R3 / R7: pending load then blank copy, channel layout
    d = rndWord();
    loadWord(1'b0, d);
    latPulse(0, 1'b0);
    blankPulse();
    chk(gsActive == d, "R7 blank copy", gsActive, d);
    chk(gsActive[16*5 +: 16] == d[80 +: 16], "R3 channel 5 field", {240'b0, gsActive[80 +: 16]}, {240'b0, d[80 +: 16]});
    chk(gsActive[255:240] == d[255:240], "R3 channel 15 field", {240'b0, gsActive[255:240]}, {240'b0, d[255:240]});
    dOld = d;

    // R8: write without transfer leaves active frame alone
    d = rndWord();
    loadWord(1'b0, d);
    latPulse(0, 1'b0);
    repeat (3) @(negedge clk);
    chk(gsActive == dOld, "R8 active held", gsActive, dOld);

    // R4: control word does not touch pending frame
    loadWord(1'b1, rndWord());
    latPulse(0, 1'b0);
    blankPulse();
    chk(gsActive == d, "R4 pending untouched", gsActive, d);

    // R5: timing-reset write goes straight to active and clears the counter
    repeat (5) gsPulse();
    timingReset = 1;
    d = rndWord();
    loadWord(1'b0, d);
    latPulse(0, 1'b0);
    chk(gsActive == d, "R5 direct transfer", gsActive, d);
    timingReset = 0;
    dOld = d;

    // R10 / R6: full period after the clear
    d = rndWord();
    loadWord(1'b0, d);
    latPulse(0, 1'b0);
    autoRepeat = 1;
    for (int i = 0; i < (1 << CNT_W) - 1; i++) gsPulse();
    chk(gsActive == dOld, "R10 no transfer before wrap", gsActive, dOld);
    gsPulse();
    chk(gsActive == d, "R6 transfer at wrap", gsActive, d);
    autoRepeat = 0;
    loadWord(1'b0, rndWord());
    latPulse(0, 1'b0);
    for (int i = 0; i < (1 << CNT_W); i++) gsPulse();
    chk(gsActive == d, "R6 repeat off holds", gsActive, d);

    // R9: coincident latch and shift
    d = rndWord();
    loadWord(1'b0, d);
    latPulse(1, 1'b1);
    blankPulse();
    chk(gsActive == d, "R9 pre-shift contents", gsActive, d);
    chk(serOut == mSr[FW], "R9 shift still taken", {255'b0, serOut}, {255'b0, mSr[FW]});

    // random mix
    for (int it = 0; it < 24; it++) begin
      autoRepeat  = $urandom_range(0, 1);
      timingReset = $urandom_range(0, 1);
      loadWord(($urandom_range(0, 3) == 0), rndWord());
      latPulse($urandom_range(0, 1), $urandom_range(0, 1));
      for (int g = 0; g < $urandom_range(0, 20); g++) gsPulse();
      if ($urandom_range(0, 3) == 0) blankPulse();
      chk(gsActive == mL2, "R6/R7/R8 random frame", gsActive, mL2);
      chk(serOut == mSr[FW], "R1 random serOut", {255'b0, serOut}, {255'b0, mSr[FW]});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule